// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Status Flags

This block moves 36-bit words from a write port to a read port whose clocks have no fixed relation. It holds up to 64 words. Each port qualifies an access with a chip select, a direction select, an enable and a mailbox select. A read loads the oldest stored word into a registered output. Both pointers are binary counters one bit wider than the address. They cross between the domains in Gray code and go through two flip-flop stages before they are compared.

The block drives four active-low flags. The read domain produces empty and almost-empty. The write domain produces full and almost-full. Each flag is worked out from the local pointer and the synchronized copy of the remote pointer. A status change made by the far port therefore shows up on the second rising edge of the local clock. A 2-bit select is sampled while reset is held and picks the almost-threshold X.

Top module: `xclk_fifo`

## Requirements
- R1: Words leave the output register in the order they were written, with their 36-bit values unchanged. At most 64 words are held.
- R2: A write is taken on a rising `wclk` edge only when `w_cs_n`=0, `w_dir`=1, `w_en`=1, `w_mbx`=0 and `w_full_n`=1. Any other combination leaves the stored contents and the write pointer as they were.
- R3: A read is taken on a rising `rclk` edge only when `r_cs_n`=0, `r_dir`=0, `r_en`=1, `r_mbx`=0 and `r_empty_n`=1. In every other cycle `r_data` holds its value.
- R4: `r_empty_n` is low while no written word is visible to the read domain. A write becomes visible on the second rising `rclk` edge after the write, and the word can be read on the edge after that. Read attempts while it is low have no effect.
- R5: `w_full_n` is low while 64 words are counted as held. A read frees a location for writing on the second rising `wclk` edge after the read. Write attempts while it is low have no effect.
- R6: `r_aempty_n` is low when the read domain counts 0 to X words and high otherwise.
- R7: `w_afull_n` is low when the write domain counts 64−X to 64 words and high otherwise.
- R8: X is loaded while `rst_n` is low from `thr_sel`: 0 gives 4, 1 gives 8, 2 gives 16, 3 gives 32.
- R9: Reset is synchronous and active low in each domain. It empties the FIFO and clears `r_data` to zero. It drives `r_empty_n` and `r_aempty_n` low and `w_full_n` and `w_afull_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously by both clocks |
| thr_sel | input | 2 | Almost-threshold preset select, sampled during reset |
| w_cs_n | input | 1 | Write port chip select, active low |
| w_dir | input | 1 | Write port direction, 1 = write |
| w_en | input | 1 | Write port enable |
| w_mbx | input | 1 | Write port mailbox select, must be 0 for a FIFO write |
| w_data | input | 36 | Write data |
| w_full_n | output | 1 | Full flag, active low, write domain |
| w_afull_n | output | 1 | Almost-full flag, active low, write domain |
| r_cs_n | input | 1 | Read port chip select, active low |
| r_dir | input | 1 | Read port direction, 0 = read |
| r_en | input | 1 | Read port enable |
| r_mbx | input | 1 | Read port mailbox select, must be 0 for a FIFO read |
| r_data | output | 36 | Output register |
| r_empty_n | output | 1 | Empty flag, active low, read domain |
| r_aempty_n | output | 1 | Almost-empty flag, active low, read domain |

## Verification
The FIFO is exercised with four kinds of traffic. In a write-only burst the FIFO fills until full stops it. A read-only burst drains it until empty blocks it. A long mixed phase has random accesses on both ports. A reset applied while words are still held shows that the contents are discarded. The bursts test the blocking behaviour at the full and empty ends. The mixed phase, run under each of the four threshold presets, moves the count across both almost-thresholds many times. Randomly chosen wrong control bits check that only the exact qualifying combination is accepted. Because the two clocks have unrelated periods, a comparison on every cycle against a timestamp-free model catches a flag that updates one edge early or one edge late.

// File: rtl/xclk_fifo_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the dual-clock FIFO: synchronizer depth and the
// almost-threshold presets. Assumes nothing beyond IEEE 1800-2017.
package xclk_fifo_pkg;

    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        OFS_4  = 2'd0,
        OFS_8  = 2'd1,
        OFS_16 = 2'd2,
        OFS_32 = 2'd3
    } ofs_sel_e;

    // Map the reset-time select to a threshold in words.
    function automatic int unsigned ofs_words(logic [1:0] sel);
        case (ofs_sel_e'(sel))
            OFS_4:   return 32'd4;
            OFS_8:   return 32'd8;
            OFS_16:  return 32'd16;
            default: return 32'd32;
        endcase
    endfunction

endpackage

// File: rtl/xclk_ptr_sync.sv
`timescale 1ns/1ps
// Carries a Gray-coded pointer into another clock domain through a chain
// of flip-flops and returns it as binary. Assumes the input changes by at
// most one bit per source clock and STAGES is at least 2.
module xclk_ptr_sync #(
    parameter int PW     = 7,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [STAGES-1:0][PW-1:0] stg;
    logic [PW-1:0]             gray_q;

    // Shift the remote pointer through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], gray_in};
    end

    assign gray_q = stg[STAGES-1];

    // Each binary bit is the XOR of all Gray bits at or above it.
    for (genvar i = 0; i < PW; i++) begin : g_g2b
        assign bin_out[i] = ^(gray_q >> i);
    end
endmodule

// File: rtl/xclk_store.sv
`timescale 1ns/1ps
// Word storage: written on the write clock, read asynchronously by address.
// Assumes the read side only addresses words it counts as held.
module xclk_store #(
    parameter int DW = 36,
    parameter int AW = 6
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] cells [WORDS];

    // Store an accepted write word.
    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/xclk_wr_side.sv
`timescale 1ns/1ps
// Write-domain control: access qualification, write pointer, and the full
// and almost-full flags worked out from the synchronized read pointer.
// Assumes rptr_seen is already two flip-flop stages deep in this domain.
module xclk_wr_side
    import xclk_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int PW    = 7
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic [1:0]    ofs_sel,
    input  logic          cs_n,
    input  logic          dir,
    input  logic          en,
    input  logic          mbx,
    input  logic [PW-1:0] rptr_seen,
    output logic          wr_go,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wptr_gray,
    output logic          full_n,
    output logic          afull_n
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [PW-1:0] wptr_bin, wptr_nxt, fill, ofs_w;

    assign fill     = wptr_bin - rptr_seen;
    assign full_n   = (fill != DEPTH_P);
    assign afull_n  = (fill < (DEPTH_P - ofs_w));
    assign wr_go    = !cs_n && dir && en && !mbx && full_n;
    assign wptr_nxt = wptr_bin + PW'(1);
    assign waddr    = wptr_bin[AW-1:0];

    // Latch the almost-threshold while reset is held.
    always_ff @(posedge wclk) begin
        if (!rst_n) ofs_w <= PW'(ofs_words(ofs_sel));
    end

    // Advance the binary and Gray write pointers on an accepted write.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wptr_bin  <= '0;
            wptr_gray <= '0;
        end else if (wr_go) begin
            wptr_bin  <= wptr_nxt;
            wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end
endmodule

// File: rtl/xclk_rd_side.sv
`timescale 1ns/1ps
// Read-domain control: access qualification, read pointer, output register,
// and the empty and almost-empty flags worked out from the synchronized
// write pointer. Assumes wptr_seen is already two stages deep here.
module xclk_rd_side
    import xclk_fifo_pkg::*;
#(
    parameter int DW = 36,
    parameter int AW = 6,
    parameter int PW = 7
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic [1:0]    ofs_sel,
    input  logic          cs_n,
    input  logic          dir,
    input  logic          en,
    input  logic          mbx,
    input  logic [PW-1:0] wptr_seen,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rptr_gray,
    output logic [DW-1:0] r_data,
    output logic          empty_n,
    output logic          aempty_n
);
    logic [PW-1:0] rptr_bin, rptr_nxt, held, ofs_r;
    logic          rd_go;

    assign held     = wptr_seen - rptr_bin;
    assign empty_n  = (held != '0);
    assign aempty_n = (held > ofs_r);
    assign rd_go    = !cs_n && !dir && en && !mbx && empty_n;
    assign rptr_nxt = rptr_bin + PW'(1);
    assign raddr    = rptr_bin[AW-1:0];

    // Latch the almost-threshold while reset is held.
    always_ff @(posedge rclk) begin
        if (!rst_n) ofs_r <= PW'(ofs_words(ofs_sel));
    end

    // Advance the binary and Gray read pointers on an accepted read.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rptr_bin  <= '0;
            rptr_gray <= '0;
        end else if (rd_go) begin
            rptr_bin  <= rptr_nxt;
            rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
        end
    end

    // Load the oldest word into the output register on an accepted read.
    always_ff @(posedge rclk) begin
        if (!rst_n)     r_data <= '0;
        else if (rd_go) r_data <= mem_q;
    end
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
// Dual-clock FIFO top: storage, the two domain controllers and the two
// pointer synchronizers. Assumes rst_n is held for several cycles of both
// clocks so that each domain sees it.
module xclk_fifo
    import xclk_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 36
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic [1:0]    thr_sel,
    input  logic          w_cs_n,
    input  logic          w_dir,
    input  logic          w_en,
    input  logic          w_mbx,
    input  logic [DW-1:0] w_data,
    output logic          w_full_n,
    output logic          w_afull_n,
    input  logic          r_cs_n,
    input  logic          r_dir,
    input  logic          r_en,
    input  logic          r_mbx,
    output logic [DW-1:0] r_data,
    output logic          r_empty_n,
    output logic          r_aempty_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          wr_go;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wptr_gray, rptr_gray, wptr_at_r, rptr_at_w;
    logic [DW-1:0] mem_q;

    xclk_store #(.DW(DW), .AW(AW)) u_store (
        .wclk(wclk), .we(wr_go), .waddr(waddr), .wdata(w_data),
        .raddr(raddr), .rdata(mem_q)
    );

    xclk_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .ofs_sel(thr_sel),
        .cs_n(w_cs_n), .dir(w_dir), .en(w_en), .mbx(w_mbx),
        .rptr_seen(rptr_at_w), .wr_go(wr_go), .waddr(waddr),
        .wptr_gray(wptr_gray), .full_n(w_full_n), .afull_n(w_afull_n)
    );

    xclk_rd_side #(.DW(DW), .AW(AW), .PW(PW)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .ofs_sel(thr_sel),
        .cs_n(r_cs_n), .dir(r_dir), .en(r_en), .mbx(r_mbx),
        .wptr_seen(wptr_at_r), .mem_q(mem_q), .raddr(raddr),
        .rptr_gray(rptr_gray), .r_data(r_data),
        .empty_n(r_empty_n), .aempty_n(r_aempty_n)
    );

    xclk_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .gray_in(wptr_gray), .bin_out(wptr_at_r)
    );

    xclk_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .gray_in(rptr_gray), .bin_out(rptr_at_w)
    );
endmodule

// File: rtl/xclk_fifo_chk.sv
`timescale 1ns/1ps
// Assertion checker for xclk_fifo, attached by bind. Observes ports and
// the storage addresses driven by the two domain controllers.
module xclk_fifo_chk #(
    parameter int DW = 36,
    parameter int AW = 6
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          w_full_n,
    input logic          w_afull_n,
    input logic          r_empty_n,
    input logic          r_aempty_n,
    input logic          r_cs_n,
    input logic [DW-1:0] r_data,
    input logic [AW-1:0] waddr,
    input logic [AW-1:0] raddr
);
    assert_reset_wside_R9: assert property (@(posedge wclk)
        !rst_n |=> (w_full_n && w_afull_n));

    assert_reset_rside_R9: assert property (@(posedge rclk)
        !rst_n |=> (!r_empty_n && !r_aempty_n));

    assert_no_overflow_R5: assert property (@(posedge wclk) disable iff (!rst_n)
        !w_full_n |=> $stable(waddr));

    assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (!rst_n)
        !r_empty_n |=> ($stable(raddr) && $stable(r_data)));

    assert_cs_hold_R3: assert property (@(posedge rclk) disable iff (!rst_n)
        r_cs_n |=> $stable(r_data));

    assert_ae_covers_empty_R6: assert property (@(posedge rclk) disable iff (!rst_n)
        !r_empty_n |-> !r_aempty_n);

    assert_af_covers_full_R7: assert property (@(posedge wclk) disable iff (!rst_n)
        !w_full_n |-> !w_afull_n);
endmodule

bind xclk_fifo xclk_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .w_full_n(w_full_n), .w_afull_n(w_afull_n),
    .r_empty_n(r_empty_n), .r_aempty_n(r_aempty_n),
    .r_cs_n(r_cs_n), .r_data(r_data),
    .waddr(waddr), .raddr(raddr)
);

// File: tb/test_xclk_fifo.sv
`timescale 1ns/1ps
// Bench for xclk_fifo: a behavioural model keeps a word queue and totals of
// writes and reads, and each domain sees the other's total two edges late.
module test_xclk_fifo;
    localparam int DEPTH = 64;
    localparam int DW    = 36;

    logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic [1:0]    thr_sel = 2'd0;
    logic          w_cs_n = 1'b1, w_dir = 1'b0, w_en = 1'b0, w_mbx = 1'b0;
    logic [DW-1:0] w_data = '0;
    logic          r_cs_n = 1'b1, r_dir = 1'b1, r_en = 1'b0, r_mbx = 1'b0;
    logic          w_full_n, w_afull_n, r_empty_n, r_aempty_n;
    logic [DW-1:0] r_data;

    xclk_fifo #(.DEPTH(DEPTH), .DW(DW)) i_xclk_fifo (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .thr_sel(thr_sel),
        .w_cs_n(w_cs_n), .w_dir(w_dir), .w_en(w_en), .w_mbx(w_mbx),
        .w_data(w_data), .w_full_n(w_full_n), .w_afull_n(w_afull_n),
        .r_cs_n(r_cs_n), .r_dir(r_dir), .r_en(r_en), .r_mbx(r_mbx),
        .r_data(r_data), .r_empty_n(r_empty_n), .r_aempty_n(r_aempty_n)
    );

    // 250 MHz write clock; read clock on an unrelated period and phase.
    always #2 wclk = ~wclk;
    initial begin
        #0.05;
        forever #3.1 rclk = ~rclk;
    end

    int n_checks = 0, n_fails = 0, mode = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural model state.
    int            wr_total, rd_total, wv1, wv2, rv1, rv2, x_w, x_r, fw, fr;
    logic [DW-1:0] q[$];
    logic [DW-1:0] exp_rdata;

    always @(posedge wclk) begin
        if (!rst_n) begin
            wr_total = 0; rv1 = 0; rv2 = 0; q.delete();
            x_w = 4 << thr_sel;
        end else begin
            if (!w_cs_n && w_dir && w_en && !w_mbx && (wr_total - rv2) != DEPTH) begin
                q.push_back(w_data);
                wr_total++;
            end
            rv2 = rv1;
            rv1 = rd_total;
        end
    end

    always @(posedge rclk) begin
        if (!rst_n) begin
            rd_total = 0; wv1 = 0; wv2 = 0; exp_rdata = '0;
            x_r = 4 << thr_sel;
        end else begin
            if (!r_cs_n && !r_dir && r_en && !r_mbx && (wv2 - rd_total) != 0) begin
                exp_rdata = q.pop_front();
                rd_total++;
            end
            wv2 = wv1;
            wv1 = wr_total;
        end
    end

    // Per-cycle comparison in the write domain.
    always @(negedge wclk) begin
        if (rst_n) begin
            fw = wr_total - rv2;
            check(w_full_n == (fw != DEPTH), "R5 full flag (R2 write qualify)",
                  w_full_n, (fw != DEPTH));
            check(w_afull_n == (fw < DEPTH - x_w), "R7 almost-full (R8 offset)",
                  w_afull_n, (fw < DEPTH - x_w));
        end
    end

    // Per-cycle comparison in the read domain.
    always @(negedge rclk) begin
        if (rst_n) begin
            fr = wv2 - rd_total;
            check(r_empty_n == (fr != 0), "R4 empty flag latency",
                  r_empty_n, (fr != 0));
            check(r_aempty_n == (fr > x_r), "R6 almost-empty (R8 offset)",
                  r_aempty_n, (fr > x_r));
            check(r_data === exp_rdata, "R1 data order / R3 output hold",
                  r_data, exp_rdata);
        end
    end

    // Write-port stimulus: qualified access or one disqualifying bit.
    always @(negedge wclk) begin
        int r;
        bit go;
        r = int'($urandom % 8);
        w_data = DW'({$urandom, $urandom});
        go = (mode == 1) ? (r < 6) : (mode == 3) ? (r < 4) : 1'b0;
        w_cs_n = 1'b0; w_dir = 1'b1; w_en = 1'b1; w_mbx = 1'b0;
        if (!go) begin
            case (r % 4)
                0: w_cs_n = 1'b1;
                1: w_dir  = 1'b0;
                2: w_en   = 1'b0;
                default: w_mbx = 1'b1;
            endcase
        end
    end

    // Read-port stimulus: qualified access or one disqualifying bit.
    always @(negedge rclk) begin
        int r;
        bit go;
        r = int'($urandom % 8);
        go = (mode == 2) ? (r < 6) : (mode == 3) ? (r < 4) : 1'b0;
        r_cs_n = 1'b0; r_dir = 1'b0; r_en = 1'b1; r_mbx = 1'b0;
        if (!go) begin
            case (r % 4)
                0: r_cs_n = 1'b1;
                1: r_dir  = 1'b1;
                2: r_en   = 1'b0;
                default: r_mbx = 1'b1;
            endcase
        end
    end

    initial begin
        fork
            begin
                for (int s = 0; s < 4; s++) begin
                    mode = 0;
                    @(negedge wclk);
                    rst_n = 1'b0;
                    thr_sel = 2'(s);
                    repeat (8) @(negedge wclk);
                    // R9: reset state seen at the ports.
                    check(w_full_n == 1'b1, "R9 reset full_n", w_full_n, 1);
                    check(w_afull_n == 1'b1, "R9 reset afull_n", w_afull_n, 1);
                    @(negedge rclk);
                    check(r_empty_n == 1'b0, "R9 reset empty_n", r_empty_n, 0);
                    check(r_aempty_n == 1'b0, "R9 reset aempty_n", r_aempty_n, 0);
                    check(r_data == '0, "R9 reset output register", r_data, 0);
                    @(negedge wclk);
                    rst_n = 1'b1;
                    mode = 1; repeat (120) @(negedge wclk);
                    mode = 0; repeat (10)  @(negedge rclk);
                    mode = 2; repeat (120) @(negedge rclk);
                    mode = 3; repeat (3000) @(negedge wclk);
                end
                mode = 2; repeat (200) @(negedge rclk);
                mode = 0; repeat (10)  @(negedge wclk);
            end
            begin
                repeat (100000) @(posedge wclk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule